// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block guards a system against software that stops making progress. A counter runs on the system clock while the watchdog is enabled. When the count reaches the selected period, the first timeout raises a one-cycle fast interrupt request and sets a pending flag. If software has not cleared that flag before the counter reaches the period again, the block drives a fixed-length system reset pulse. After the pulse ends, every setting returns to its disabled default.

Software reaches the block through a simple write port with three addresses. Address 0 is the control word. Address 1 restarts the count, but only when the data equals a fixed key. Address 2 clears the pending flag. Once a lock bit in the control word is set, the enable and period fields ignore writes until the next reset, so a stray store cannot turn the watchdog off. The period is 2^(MIN_EXP+k) cycles for a 4-bit code k. MIN_EXP defaults to 16, which spans 2^16 to 2^31 cycles.

Top module: `wdog_escalate`

## Requirements
- R1: After the synchronous reset `rst`, `irq_o`, `flag_o` and `sys_rst_o` are all low and the counter is disabled, so no timeout follows.
- R2: A control write (address 0) with bit 0 (enable) set and bits 4:1 holding code k produces the first timeout exactly 2^(MIN_EXP+k) cycles after the write's clock edge.
- R3: At a timeout with the flag clear, `irq_o` is high for exactly one cycle, `flag_o` goes high in the same cycle and stays high, and the count restarts from zero.
- R4: At a timeout with the flag still set, `sys_rst_o` rises one full period after the first timeout and stays high for exactly RST_LEN (16) cycles.
- R5: A write to address 2 with bit 0 set clears `flag_o` in the cycle after the write, so the next timeout is again a first-stage interrupt rather than a reset.
- R6: A write to address 1 whose data equals KEY restarts the count from zero, so the next timeout comes one full period after that write; any other data value leaves the count unchanged.
- R7: Control bit 5 (lock) is sticky; while it is set, later control writes do not change enable or period.
- R8: While `sys_rst_o` is high, all writes are ignored. When the pulse ends, the flag clears and enable, period and lock return to their defaults, so a new control write is accepted and no timeout occurs until then.
- R9: Clearing enable stops the counter and resets it, so no timeout follows while the watchdog is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 2 | 0 control, 1 restart key, 2 flag clear |
| wr_data | input | DW | Write data |
| irq_o | output | 1 | Fast interrupt request, one-cycle pulse |
| flag_o | output | 1 | Pending first-timeout flag |
| sys_rst_o | output | 1 | System reset pulse, RST_LEN cycles |

## Verification
A write takes effect at the clock edge that samples it. The first timeout is therefore due exactly P cycles after that edge, and a restart with the key moves it to P cycles after the restart edge. The reset pulse rises P cycles after the interrupt and falls RST_LEN cycles after it rises. The bench records the edge number of every write, pushes each interrupt, reset rise and reset fall into a queue with the edge at which it is due, and a monitor that samples on the falling clock edge pops and compares each event as it appears. Any event that arrives early, late or unexpectedly, such as one after an ignored write, is reported as a mismatch. The bench uses a small MIN_EXP so that the periods fit a short run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SEL_W         = 4;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SEL_LSB  = 1;
  localparam int CTRL_LOCK_BIT = 5;
  localparam int CLR_BIT       = 0;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_KICK  = 2'd1,
    ADDR_CLEAR = 2'd2
  } wdog_addr_e;
endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
#(
  parameter int DW = 16,
  parameter logic [DW-1:0] KEY = 16'h5A3C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             restore,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic             en,
  output logic [SEL_W-1:0] sel,
  output logic             kick,
  output logic             clr_req
);
  logic lock;
  logic wr_ok;

  assign wr_ok   = wr_en && !busy;
  assign kick    = wr_ok && (wr_addr == ADDR_KICK) && (wr_data == KEY);
  assign clr_req = wr_ok && (wr_addr == ADDR_CLEAR) && wr_data[CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst || restore) begin
      en   <= 1'b0;
      sel  <= '0;
      lock <= 1'b0;
    end else if (wr_ok && (wr_addr == ADDR_CTRL)) begin
      if (!lock) begin
        en  <= wr_data[CTRL_EN_BIT];
        sel <= wr_data[CTRL_SEL_LSB +: SEL_W];
      end
      lock <= lock | wr_data[CTRL_LOCK_BIT];
    end
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int MIN_EXP = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             hold,
  input  logic             kick,
  input  logic [SEL_W-1:0] sel,
  output logic             timeout
);
  localparam int CW = MIN_EXP + (1 << SEL_W);

  logic [CW-1:0] count;
  logic [CW-1:0] term;
  logic [CW-1:0] one;

  assign one     = CW'(1);
  assign term    = (one << (MIN_EXP + int'(sel))) - one;
  assign timeout = en && !hold && !kick && (count == term);

  always_ff @(posedge clk) begin
    if (rst || !en || kick || timeout) count <= '0;
    else if (!hold)                   count <= count + one;
  end
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage #(
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic timeout,
  input  logic clr_req,
  output logic flag,
  output logic irq,
  output logic sys_rst,
  output logic restore
);
  localparam int PW = $clog2(RST_LEN + 1);

  logic [PW-1:0] pc;

  assign restore = sys_rst && (pc == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      irq     <= 1'b0;
      sys_rst <= 1'b0;
      pc      <= '0;
    end else begin
      irq <= 1'b0;
      if (sys_rst) begin
        if (pc == '0) begin
          sys_rst <= 1'b0;
          flag    <= 1'b0;
        end else begin
          pc <= pc - PW'(1);
        end
      end else if (timeout) begin
        if (flag) begin
          sys_rst <= 1'b1;
          pc      <= PW'(RST_LEN - 1);
        end else begin
          flag <= 1'b1;
          irq  <= 1'b1;
        end
      end else if (clr_req) begin
        flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
  import wdog_pkg::*;
#(
  parameter int DW = 16,
  parameter logic [DW-1:0] KEY = 16'h5A3C,
  parameter int MIN_EXP = 16,
  parameter int RST_LEN = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          irq_o,
  output logic          flag_o,
  output logic          sys_rst_o
);
  logic             en, kick, clr_req, timeout, restore;
  logic [SEL_W-1:0] sel;

  wdog_cfg #(.DW(DW), .KEY(KEY)) u_cfg (
    .clk(clk), .rst(rst), .busy(sys_rst_o), .restore(restore),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en(en), .sel(sel), .kick(kick), .clr_req(clr_req)
  );

  wdog_count #(.MIN_EXP(MIN_EXP)) u_count (
    .clk(clk), .rst(rst), .en(en), .hold(sys_rst_o), .kick(kick),
    .sel(sel), .timeout(timeout)
  );

  wdog_stage #(.RST_LEN(RST_LEN)) u_stage (
    .clk(clk), .rst(rst), .timeout(timeout), .clr_req(clr_req),
    .flag(flag_o), .irq(irq_o), .sys_rst(sys_rst_o), .restore(restore)
  );
endmodule

// File: rtl/wdog_escalate_chk.sv
module wdog_escalate_chk #(
  parameter int RST_LEN = 16
) (
  input logic clk,
  input logic rst,
  input logic irq,
  input logic flag,
  input logic sys_rst
);
  localparam int HW = $clog2(RST_LEN + 1) + 1;
  logic [HW-1:0] hc;

  always_ff @(posedge clk) begin
    if (rst)          hc <= '0;
    else if (sys_rst) hc <= hc + HW'(1);
    else              hc <= '0;
  end

  assert_irq_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  assert_irq_with_flag_R3: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);
  assert_reset_needs_flag_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst) |-> flag);
  assert_pulse_length_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> (hc == HW'(RST_LEN)));
  assert_restore_clears_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> (!flag && !irq));
  assert_no_irq_in_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    sys_rst |-> !irq);
endmodule

bind wdog_escalate wdog_escalate_chk #(.RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .rst(rst), .irq(irq_o), .flag(flag_o), .sys_rst(sys_rst_o)
);

// File: tb/test_wdog_escalate.sv
module test_wdog_escalate;
  localparam int DW = 16;
  localparam logic [DW-1:0] KEY = 16'h5A3C;
  localparam int MIN_EXP = 4;
  localparam int RST_LEN = 16;
  localparam int EV_IRQ = 0, EV_UP = 1, EV_DN = 2;

  typedef struct { int cyc; int kind; string tag; } ev_t;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic irq_o, flag_o, sys_rst_o;

  int cyc = 0;
  int n_cmp = 0, n_bad = 0;
  ev_t exp_q[$];
  string phase = "R1";
  logic prev_rst = 0;

  wdog_escalate #(.DW(DW), .KEY(KEY), .MIN_EXP(MIN_EXP), .RST_LEN(RST_LEN))
    i_wdog_escalate (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .irq_o(irq_o), .flag_o(flag_o), .sys_rst_o(sys_rst_o));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int per(int k); return 1 << (MIN_EXP + k); endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic push(input int c, input int k, input string tag);
    ev_t e; e.cyc = c; e.kind = k; e.tag = tag; exp_q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d, output int edge_c);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0; edge_c = cyc;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: pops expected events as the design produces them
  always @(negedge clk) begin
    if (!rst) begin
      int k;
      bit seen;
      seen = 1'b0; k = -1;
      if (irq_o) begin seen = 1; k = EV_IRQ; end
      if (sys_rst_o && !prev_rst) begin seen = 1; k = EV_UP; end
      if (!sys_rst_o && prev_rst) begin seen = 1; k = EV_DN; end
      if (seen) begin
        if (exp_q.size() == 0) begin
          check(0, {phase, " unexpected event kind"}, k, -1);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          check(e.kind == k, {e.tag, " event kind"}, k, e.kind);
          check(e.cyc == cyc, {e.tag, " event cycle"}, cyc, e.cyc);
        end
      end
    end
    prev_rst = sys_rst_o;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int w, k, w2, d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check(irq_o == 0, "R1 irq", irq_o, 0);
    check(flag_o == 0, "R1 flag", flag_o, 0);
    check(sys_rst_o == 0, "R1 sys_rst", sys_rst_o, 0);
    repeat (40) @(negedge clk);

    // R2/R3/R5: period code 0, clear flag, second timeout is first-stage
    phase = "R2";
    wr(2'd0, 16'h0001, w);
    push(w + per(0), EV_IRQ, "R2");
    wait_until(w + per(0) + 2);
    check(flag_o == 1, "R3 flag set", flag_o, 1);
    wr(2'd2, 16'h0001, d);
    check(flag_o == 0, "R5 flag cleared", flag_o, 0);
    push(w + 2 * per(0), EV_IRQ, "R5");
    wait_until(w + 2 * per(0) + 2);
    check(flag_o == 1, "R3 flag set again", flag_o, 1);
    wr(2'd2, 16'h0001, d);
    wr(2'd0, 16'h0000, d);
    phase = "R9";
    repeat (80) @(negedge clk);
    check(flag_o == 0, "R9 idle flag", flag_o, 0);

    // R6/R4: code 2, wrong key ignored, right key restarts, then escalation
    phase = "R6";
    wr(2'd0, 16'h0005, w);
    wait_until(w + 20);
    wr(2'd1, KEY ^ 16'h0001, d);
    wait_until(w + 40);
    wr(2'd1, KEY, k);
    push(k + per(2), EV_IRQ, "R6");
    push(k + 2 * per(2), EV_UP, "R4");
    push(k + 2 * per(2) + RST_LEN, EV_DN, "R4");
    wait_until(k + per(2) + 2);
    check(flag_o == 1, "R3 flag after kick timeout", flag_o, 1);
    wait_until(k + 2 * per(2) + 2);
    check(sys_rst_o == 1, "R4 reset active", sys_rst_o, 1);
    phase = "R8";
    wr(2'd0, 16'h0001, d);
    wr(2'd2, 16'h0001, d);
    check(flag_o == 1, "R8 clear ignored in pulse", flag_o, 1);
    wait_until(k + 2 * per(2) + RST_LEN + 2);
    check(flag_o == 0, "R8 flag restored", flag_o, 0);
    check(sys_rst_o == 0, "R8 pulse over", sys_rst_o, 0);
    repeat (100) @(negedge clk);

    // R7: lock keeps enable and period despite later writes
    phase = "R7";
    wr(2'd0, 16'h0021, w);
    push(w + per(0), EV_IRQ, "R7");
    wr(2'd0, 16'h0006, d);
    wait_until(w + per(0) + 2);
    wr(2'd2, 16'h0001, d);
    push(w + 2 * per(0), EV_IRQ, "R7");
    push(w + 3 * per(0), EV_UP, "R7");
    push(w + 3 * per(0) + RST_LEN, EV_DN, "R7");
    wait_until(w + 3 * per(0) + RST_LEN + 2);

    // R8: lock cleared after pulse, new config accepted
    phase = "R8";
    wr(2'd0, 16'h0003, w2);
    push(w2 + per(1), EV_IRQ, "R8");
    wait_until(w2 + per(1) + 2);
    check(flag_o == 1, "R8 new config timeout", flag_o, 1);
    wr(2'd0, 16'h0000, d);
    wr(2'd2, 16'h0001, d);
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R8 all events seen", exp_q.size(), 0);
    check(flag_o == 0, "R9 final flag", flag_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule